// File: doc/BRIEF.md
# Programmable Video Sync Timing Generator

This block produces the vertical sync, horizontal sync and data-enable strobes of a progressive video frame, one step per pixel clock. Every length comes from configuration inputs counted in pixel clocks or lines. The frame length is the sum of the vertical-sync delay, its high time and its low time. The horizontal sync and the data enable are each a train of high/low pulses. Each train starts at a fixed pixel offset from the vertical-sync edge and repeats for a programmed number of lines.

All three strobes are timed from one frame pixel counter, so they stay phase-locked. The configuration is copied into shadow registers only at a frame boundary, which is either the first enabled clock or the wrap of the frame counter. Changes made during a frame therefore take effect at the next frame. Alongside the enable strobe, the block reports the pixel column and line inside the active area, for use by a downstream pattern painter. All high and low lengths are assumed to be at least 1.

Top module: `video_sync_gen`

## Requirements
- R1: After reset, and on every clock while `en` is low, `vs_o`, `hs_o`, `de_o`, `px_x` and `px_y` are all 0.
- R2: The first clock edge that samples `en` high starts a frame and loads the configuration. The outputs for frame pixel 0 appear after the next edge, and one pixel follows per clock after that. A frame lasts `vs_delay + vs_high_len + vs_low_len` clocks, and then the next frame starts at pixel 0.
- R3: `vs_o` is 1 exactly for frame pixels p with `vs_delay <= p < vs_delay + vs_high_len`.
- R4: Let S = `vs_delay + vs_to_hs` and P = `hs_high_len + hs_low_len`. `hs_o` is 1 for pixel p when p >= S, p - S < `hs_lines`·P and (p - S) mod P < `hs_high_len`. When `hs_lines` is 0, no HS pulse is produced.
- R5: The data enable follows the same rule as R4, using S = `vs_delay + vs_to_de`, the lengths `de_high_len`/`de_low_len` and the line count `de_lines`.
- R6: A pulse train that would run past the end of the frame is cut off at the frame boundary. The train then starts again at its programmed offset in the next frame.
- R7: The configuration inputs are sampled only at a frame boundary. A change made during a frame has no effect on the outputs until the next frame.
- R8: An edge that samples `en` low forces all outputs to 0 after that edge and discards the frame position. Re-enabling starts a new frame from pixel 0.
- R9: While `de_o` is 1, `px_x` is the pixel index within the active line, starting at 0, and `px_y` is the active line index, starting at 0. While `de_o` is 0, both are 0.
- R10: Use the reference timing: horizontal front porch 88, sync 44 and back porch 148; vertical front porch 4, sync 5 and back porch 36; VS delay 0. With these values, the first data enable rises `line_total·(5+36) + (44+148)` clocks after the VS rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low stops the frame and clears the outputs |
| vs_delay | input | 24 | Pixels from frame start to the VS rise |
| vs_high_len | input | 24 | VS high time in pixels |
| vs_low_len | input | 24 | VS low time in pixels |
| vs_to_hs | input | 24 | Offset from the VS rise to the first HS rise |
| hs_high_len | input | 16 | HS high width in pixels |
| hs_low_len | input | 16 | HS low width in pixels |
| hs_lines | input | 16 | Number of HS pulses per frame |
| vs_to_de | input | 24 | Offset from the VS rise to the first DE rise |
| de_high_len | input | 16 | DE high width (active pixels per line) |
| de_low_len | input | 16 | DE low width in pixels |
| de_lines | input | 16 | Number of DE lines per frame |
| vs_o | output | 1 | Vertical sync |
| hs_o | output | 1 | Horizontal sync |
| de_o | output | 1 | Data enable |
| px_x | output | 16 | Active pixel column, valid while de_o is 1 |
| px_y | output | 16 | Active line index, valid while de_o is 1 |

## Verification
The hardest situations to reach are those where a configuration write lands in the middle of an open HS or DE line train, and where a train is still running when the frame counter wraps. Both need the frame boundary to occur while segment counters are part-way through a line.

The stimulus uses short random frames, so wraps happen every few dozen clocks. Line trains are sized at random so that they often overrun the frame. New configurations are applied at random clocks, and `en` is occasionally dropped for a single clock. One long run with the reference timing checks the absolute offset of the first DE rise and the full frame period.

// File: rtl/sync_tgen_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and the segment-phase type of the sync timing generator.
// Assumes: long (vertical/offset) fields are wider than short (line) fields.
package sync_tgen_pkg;
    localparam int LONG_W  = 24;   // width of frame-scale pixel counts
    localparam int SHORT_W = 16;   // width of line-scale pixel counts
    localparam int FRAME_W = LONG_W + 2; // holds the sum of three long fields

    typedef enum logic {
        SEG_LOW  = 1'b0,
        SEG_HIGH = 1'b1
    } seg_e;
endpackage

// File: rtl/stg_frame_ctr.sv
`timescale 1ns/1ps
// Module: frame pixel counter.
// Counts pixels 0..flen-1 while enabled and wraps. load_o marks a frame
// boundary (first enabled clock or wrap), where the shadow config is refreshed.
// Assumes: flen >= 2 when running; a low en clears the position.
module stg_frame_ctr #(
    parameter int FW = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [FW-1:0] flen,
    output logic          run_o,
    output logic [FW-1:0] fc_o,
    output logic          load_o
);
    logic          run_q;
    logic [FW-1:0] fc_q;

    // frame boundary: start of run or last pixel of the frame
    assign load_o = en && (!run_q || (fc_q == flen - 1'b1));

    // advance, wrap or clear the frame position
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            run_q <= 1'b0;
            fc_q  <= '0;
        end else if (load_o) begin
            run_q <= 1'b1;
            fc_q  <= '0;
        end else begin
            fc_q  <= fc_q + 1'b1;
        end
    end

    assign run_o = run_q;
    assign fc_o  = fc_q;

    AST_FC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && flen != '0) |-> (fc_q < flen)); // R2
endmodule

// File: rtl/stg_pulse_train.sv
`timescale 1ns/1ps
// Module: pulse train generator.
// When the frame counter reaches start, emits 'lines' repetitions of
// seg_hi high pixels then seg_lo low pixels. pulse_o is registered, so it
// shows the value for the pixel the counter held one clock earlier.
// Assumes: seg_hi >= 1 and seg_lo >= 1; a train is cut at frame wrap.
module stg_pulse_train
    import sync_tgen_pkg::*;
#(
    parameter int FW = 26,
    parameter int LW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          run,
    input  logic [FW-1:0] fc,
    input  logic [FW-1:0] start,
    input  logic [LW-1:0] seg_hi,
    input  logic [LW-1:0] seg_lo,
    input  logic [LW-1:0] lines,
    output logic          pulse_o
);
    logic          on_q;
    seg_e          ph_q;
    logic [LW-1:0] segc_q;
    logic [LW-1:0] ln_q;
    logic          pulse_q;
    logic [LW-1:0] ln_nxt;

    // number of completed lines once the current low segment ends
    assign ln_nxt = ln_q + 1'b1;

    // segment / line sequencing for the pixel held in fc
    always_ff @(posedge clk) begin
        if (!rst_n || !(en && run)) begin
            on_q    <= 1'b0;
            ph_q    <= SEG_LOW;
            segc_q  <= '0;
            ln_q    <= '0;
            pulse_q <= 1'b0;
        end else if (fc == start && lines != '0) begin
            on_q    <= 1'b1;
            ph_q    <= SEG_HIGH;
            segc_q  <= LW'(1);
            ln_q    <= '0;
            pulse_q <= 1'b1;
        end else if (fc == '0) begin
            on_q    <= 1'b0;
            ph_q    <= SEG_LOW;
            pulse_q <= 1'b0;
        end else if (on_q) begin
            if (ph_q == SEG_HIGH) begin
                if (segc_q == seg_hi) begin
                    ph_q    <= SEG_LOW;
                    segc_q  <= LW'(1);
                    pulse_q <= 1'b0;
                end else begin
                    segc_q  <= segc_q + 1'b1;
                    pulse_q <= 1'b1;
                end
            end else if (segc_q == seg_lo) begin
                if (ln_nxt == lines) begin
                    on_q    <= 1'b0;
                    pulse_q <= 1'b0;
                end else begin
                    ph_q    <= SEG_HIGH;
                    segc_q  <= LW'(1);
                    ln_q    <= ln_nxt;
                    pulse_q <= 1'b1;
                end
            end else begin
                segc_q  <= segc_q + 1'b1;
                pulse_q <= 1'b0;
            end
        end else begin
            pulse_q <= 1'b0;
        end
    end

    assign pulse_o = pulse_q;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pulse_o); // R8
    AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (on_q && fc != '0) |-> (ln_q < lines)); // R4
    AST_SEG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (on_q && fc != '0 && ph_q == SEG_HIGH) |-> (segc_q <= seg_hi)); // R4
endmodule

// File: rtl/stg_pos_ctr.sv
`timescale 1ns/1ps
// Module: active-area position counter.
// Counts column while DE is high and advances the line on each DE line end.
// Registers prepare the position of the next pixel from the current DE.
// Assumes: clr is raised at every frame start and whenever running stops.
module stg_pos_ctr #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          de,
    output logic [SW-1:0] px_x,
    output logic [SW-1:0] px_y
);
    logic [SW-1:0] x_q;
    logic [SW-1:0] y_q;

    // column counts DE-high pixels; line steps when a DE run has ended
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            x_q <= '0;
            y_q <= '0;
        end else if (de) begin
            x_q <= x_q + 1'b1;
        end else begin
            if (x_q != '0) y_q <= y_q + 1'b1;
            x_q <= '0;
        end
    end

    assign px_x = de ? x_q : '0;
    assign px_y = de ? y_q : '0;
endmodule

// File: rtl/video_sync_gen.sv
`timescale 1ns/1ps
// Module: programmable video sync timing generator (top).
// Shadows the timing config at frame boundaries, runs one frame counter and
// derives VS, HS and DE as three pulse trains plus the active position.
// Assumes: every high/low length is >= 1.
module video_sync_gen
    import sync_tgen_pkg::*;
#(
    parameter int LW = LONG_W,
    parameter int SW = SHORT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [LW-1:0] vs_delay,
    input  logic [LW-1:0] vs_high_len,
    input  logic [LW-1:0] vs_low_len,
    input  logic [LW-1:0] vs_to_hs,
    input  logic [SW-1:0] hs_high_len,
    input  logic [SW-1:0] hs_low_len,
    input  logic [SW-1:0] hs_lines,
    input  logic [LW-1:0] vs_to_de,
    input  logic [SW-1:0] de_high_len,
    input  logic [SW-1:0] de_low_len,
    input  logic [SW-1:0] de_lines,
    output logic          vs_o,
    output logic          hs_o,
    output logic          de_o,
    output logic [SW-1:0] px_x,
    output logic [SW-1:0] px_y
);
    localparam int FW     = LW + 2;
    localparam int NTRAIN = 3;   // 0: VS, 1: HS, 2: DE

    logic [LW-1:0] sh_dly, sh_vsh, sh_vsl, sh_v2h, sh_v2d;
    logic [SW-1:0] sh_hsh, sh_hsl, sh_hsc, sh_deh, sh_del, sh_dec;
    logic [FW-1:0] flen;
    logic          run;
    logic          load;
    logic [FW-1:0] fc;

    logic [FW-1:0] t_start [NTRAIN];
    logic [LW-1:0] t_hi    [NTRAIN];
    logic [LW-1:0] t_lo    [NTRAIN];
    logic [LW-1:0] t_cnt   [NTRAIN];
    logic [NTRAIN-1:0] t_pulse;

    // refresh the shadow configuration at each frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_dly <= '0; sh_vsh <= '0; sh_vsl <= '0; sh_v2h <= '0; sh_v2d <= '0;
            sh_hsh <= '0; sh_hsl <= '0; sh_hsc <= '0;
            sh_deh <= '0; sh_del <= '0; sh_dec <= '0;
        end else if (load) begin
            sh_dly <= vs_delay;    sh_vsh <= vs_high_len; sh_vsl <= vs_low_len;
            sh_v2h <= vs_to_hs;    sh_v2d <= vs_to_de;
            sh_hsh <= hs_high_len; sh_hsl <= hs_low_len;  sh_hsc <= hs_lines;
            sh_deh <= de_high_len; sh_del <= de_low_len;  sh_dec <= de_lines;
        end
    end

    assign flen = FW'(sh_dly) + FW'(sh_vsh) + FW'(sh_vsl);

    stg_frame_ctr #(.FW(FW)) u_frame (
        .clk(clk), .rst_n(rst_n), .en(en), .flen(flen),
        .run_o(run), .fc_o(fc), .load_o(load)
    );

    // per-train parameters taken from the shadow registers
    assign t_start[0] = FW'(sh_dly);
    assign t_hi[0]    = sh_vsh;
    assign t_lo[0]    = sh_vsl;
    assign t_cnt[0]   = LW'(1);
    assign t_start[1] = FW'(sh_dly) + FW'(sh_v2h);
    assign t_hi[1]    = LW'(sh_hsh);
    assign t_lo[1]    = LW'(sh_hsl);
    assign t_cnt[1]   = LW'(sh_hsc);
    assign t_start[2] = FW'(sh_dly) + FW'(sh_v2d);
    assign t_hi[2]    = LW'(sh_deh);
    assign t_lo[2]    = LW'(sh_del);
    assign t_cnt[2]   = LW'(sh_dec);

    for (genvar g = 0; g < NTRAIN; g++) begin : g_train
        stg_pulse_train #(.FW(FW), .LW(LW)) u_train (
            .clk(clk), .rst_n(rst_n), .en(en), .run(run), .fc(fc),
            .start(t_start[g]), .seg_hi(t_hi[g]), .seg_lo(t_lo[g]),
            .lines(t_cnt[g]), .pulse_o(t_pulse[g])
        );
    end

    assign vs_o = t_pulse[0];
    assign hs_o = t_pulse[1];
    assign de_o = t_pulse[2];

    stg_pos_ctr #(.SW(SW)) u_pos (
        .clk(clk), .rst_n(rst_n),
        .clr(!(en && run) || fc == '0),
        .de(de_o), .px_x(px_x), .px_y(px_y)
    );

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(sh_dec) && $stable(sh_vsh) && $stable(sh_hsc))); // R7
endmodule

// File: tb/video_sync_gen_test.sv
`timescale 1ns/1ps
// Bench: random and directed timing configurations checked each clock
// against a model computed from the requirements.
module video_sync_gen_test;
    localparam int LW = 24;
    localparam int SW = 16;

    typedef struct {
        int dly, vsh, vsl, v2h, hsh, hsl, hsc, v2d, deh, del, dec;
    } cfg_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    cfg_t ci;
    logic vs_o, hs_o, de_o;
    logic [SW-1:0] px_x, px_y;

    int n_chk = 0;
    int n_fail = 0;
    string phase = "R1";

    // model state
    bit   m_run = 0;
    bit   m_valid = 0;
    int   m_fc = 0;
    int   m_p = 0;
    cfg_t m_sh;
    cfg_t m_cfg;

    always #2.5 clk = ~clk;

    video_sync_gen uut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .vs_delay(LW'(ci.dly)), .vs_high_len(LW'(ci.vsh)), .vs_low_len(LW'(ci.vsl)),
        .vs_to_hs(LW'(ci.v2h)), .hs_high_len(SW'(ci.hsh)), .hs_low_len(SW'(ci.hsl)),
        .hs_lines(SW'(ci.hsc)), .vs_to_de(LW'(ci.v2d)), .de_high_len(SW'(ci.deh)),
        .de_low_len(SW'(ci.del)), .de_lines(SW'(ci.dec)),
        .vs_o(vs_o), .hs_o(hs_o), .de_o(de_o), .px_x(px_x), .px_y(px_y)
    );

    function automatic int rnd(int lo, int hi);
        return lo + int'($urandom % (hi - lo + 1));
    endfunction

    function automatic cfg_t rand_cfg();
        cfg_t c;
        c.dly = rnd(0, 6);  c.vsh = rnd(1, 20); c.vsl = rnd(1, 60);
        c.v2h = rnd(0, 30); c.hsh = rnd(1, 6);  c.hsl = rnd(1, 8);  c.hsc = rnd(0, 9);
        c.v2d = rnd(0, 30); c.deh = rnd(1, 8);  c.del = rnd(1, 6);  c.dec = rnd(0, 7);
        return c;
    endfunction

    function automatic int flen(cfg_t c);
        return c.dly + c.vsh + c.vsl;
    endfunction

    function automatic bit train(int p, int s, int h, int l, int c);
        if (c == 0 || p < s) return 1'b0;
        if (p - s >= c * (h + l)) return 1'b0;
        return ((p - s) % (h + l)) < h;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s (%s) act=%0d exp=%0d", tag, phase, act, exp);
        end
    endtask

    // one clock: update the model at the edge, check 1 ns later
    task automatic tick();
        int evs, ehs, ede, ex, ey, s;
        @(posedge clk);
        if (!rst_n || !en) begin
            m_valid = 0; m_run = 0; m_fc = 0;
        end else begin
            m_valid = m_run; m_p = m_fc; m_cfg = m_sh;
            if (!m_run || m_fc == flen(m_sh) - 1) begin
                m_fc = 0; m_sh = ci; m_run = 1;
            end else begin
                m_fc++;
            end
        end
        #1;
        evs = 0; ehs = 0; ede = 0; ex = 0; ey = 0;
        if (m_valid) begin
            evs = train(m_p, m_cfg.dly, m_cfg.vsh, m_cfg.vsl, 1);
            ehs = train(m_p, m_cfg.dly + m_cfg.v2h, m_cfg.hsh, m_cfg.hsl, m_cfg.hsc);
            s   = m_cfg.dly + m_cfg.v2d;
            ede = train(m_p, s, m_cfg.deh, m_cfg.del, m_cfg.dec);
            if (ede != 0) begin
                ex = (m_p - s) % (m_cfg.deh + m_cfg.del);
                ey = (m_p - s) / (m_cfg.deh + m_cfg.del);
            end
            check("R3 vs_o", int'(vs_o), evs);
            check("R4 hs_o", int'(hs_o), ehs);
            check("R5 de_o", int'(de_o), ede);
            check("R9 px_x", int'(px_x), ex);
            check("R9 px_y", int'(px_y), ey);
        end else begin
            check("R1,R8 idle vs_o", int'(vs_o), 0);
            check("R1,R8 idle hs_o", int'(hs_o), 0);
            check("R1,R8 idle de_o", int'(de_o), 0);
            check("R1,R8 idle px_x", int'(px_x), 0);
            check("R1,R8 idle px_y", int'(px_y), 0);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (%s) act=1 exp=0", phase);
        finish_run();
    end

    initial begin
        int t, t_vs0, t_vs1, t_de;
        bit pv, pd;
        void'($urandom(32'd20240611));
        ci = rand_cfg();
        m_sh = ci;
        m_cfg = ci;

        // R1: reset state and idle with en low
        phase = "R1";
        repeat (4) tick();
        rst_n = 1'b1;
        repeat (4) tick();

        // R10 / R2: reference timing, active 16 x 4
        phase = "R10";
        ci.dly = 0;  ci.vsh = 5 * 296; ci.vsl = 44 * 296; ci.v2h = 0;
        ci.hsh = 44; ci.hsl = 16 + 88 + 148; ci.hsc = 49;
        ci.v2d = 296 * 41 + 192; ci.deh = 16; ci.del = 280; ci.dec = 4;
        en = 1'b1;
        t = 0; t_vs0 = -1; t_vs1 = -1; t_de = -1; pv = 0; pd = 0;
        while (t_vs1 < 0 && t < 40000) begin
            tick();
            t++;
            if (vs_o && !pv) begin
                if (t_vs0 < 0) t_vs0 = t; else t_vs1 = t;
            end
            if (de_o && !pd && t_de < 0) t_de = t;
            pv = vs_o; pd = de_o;
        end
        check("R2 first VS rise tick", t_vs0, 2);
        check("R10 VS-to-DE offset", t_de - t_vs0, 12328);
        check("R2 frame period", t_vs1 - t_vs0, 14504);
        en = 1'b0;
        repeat (2) tick();

        // R4: zero HS lines gives no HS
        phase = "R4";
        ci = rand_cfg(); ci.hsc = 0;
        en = 1'b1;
        repeat (200) tick();
        en = 1'b0; tick();

        // R6: trains overrunning the frame are cut and restart
        phase = "R6";
        ci = rand_cfg(); ci.vsh = 3; ci.vsl = 20; ci.hsc = 40; ci.dec = 30; ci.v2d = 2;
        en = 1'b1;
        repeat (120) tick();
        en = 1'b0; tick();

        // R7: change config mid-frame, takes effect next frame
        phase = "R7";
        ci = rand_cfg(); ci.vsh = 10; ci.vsl = 50; ci.dec = 5;
        en = 1'b1;
        repeat (15) tick();
        ci = rand_cfg(); ci.deh = 3; ci.dec = 2;
        repeat (200) tick();

        // R8: single-clock enable drop mid-frame
        phase = "R8";
        repeat (7) tick();
        en = 1'b0; tick();
        en = 1'b1;
        repeat (150) tick();
        en = 1'b0; tick();

        // random configurations, random reconfig and enable blips
        phase = "R2,R7 random";
        for (int r = 0; r < 30; r++) begin
            ci = rand_cfg();
            en = 1'b1;
            for (int k = 0; k < 300; k++) begin
                tick();
                if ($urandom % 97 == 0) ci = rand_cfg();
                en = ($urandom % 150) != 0;
            end
            en = 1'b0;
            tick();
        end

        finish_run();
    end
endmodule